// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This block sits beside a CAN protocol engine. It gathers the engine's error events into latched flags and keeps the transmit and receive error counters. From those counters it works out when the node enters the warning, passive and bus-off states. The flags are gated by a per-flag enable register. Their combined result shows as one summary bit in an interrupt status register and, behind a further enable, drives a single error interrupt line.

Every event input is a one-cycle pulse from the protocol engine. Software reaches the registers through a plain single-cycle register port:
- A write happens on a clock edge while `reg_we` is high.
- Read data is combinational from `reg_addr`.
- There is no stream traffic, so no valid/ready handshake or back-pressure is involved.

Software clears a flag by writing 0 to its bit. A 1 written to a flag bit leaves that flag as it is.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset, every register reads 0, `err_irq` is 0 and `bus_off` is 0.
- R2: A pulse on `src_evt` latches each pulsed bit into the error-source register at address 2 and sets error flag bit 0. The error-source bits are: 6 ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff. Bit 7 of address 2 is a plain read/write mode bit.
- R3: The error flag register at address 0 latches three more events. A `lock_evt` pulse sets bit 7, an `ovld_evt` pulse sets bit 6 and an `ovrn_evt` pulse sets bit 5.
- R4: For the flags at address 0 and at address 2 bits 6..0, writing 0 to a bit clears it and writing 1 leaves it unchanged.
- R5: If an event and a clearing write reach the same flag bit in the same cycle, the flag ends up set.
- R6: The interrupt status register at address 3 reads bit 5 as 1 exactly when some flag is set and its bit in the enable register at address 1 is also 1. All other bits of address 3 read 0. `err_irq` equals that bit 5 ANDed with bit 5 of the interrupt enable register at address 4.
- R7: The error counters change on the clock edge that samples their event pulses:
  - The transmit counter (address 5) rises by 8 on `tx_err_evt` and falls by 1 on `tx_ok_evt`.
  - The receive counter (address 6) rises by 1 on `rx_err_evt` and falls by 1 on `rx_ok_evt`.
  - Neither counter goes below 0, and the receive counter stops at 255.
- R8: Error flag bit 1 (warning) is set only on the cycle where the larger of the two counters moves from below 96 to 96 or more.
- R9: Error flag bit 2 (passive) is set only on the cycle where the larger of the two counters moves from below 128 to 128 or more.
- R10: Bus-off entry happens when the transmit counter would exceed 255. On that cycle:
  - error flag bit 3 is set;
  - `bus_off` goes to 1 and the transmit counter reads 255;
  - while `bus_off` is 1, counter events have no effect.
- R11: A `recover_evt` pulse during bus-off clears both counters, drops `bus_off` and sets error flag bit 4. Outside bus-off the pulse has no effect.
- R12: Address 7 reads 0. Writes to addresses 3, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 7 | Bus error source pulses, bit order as in R2 |
| lock_evt | input | 1 | Bus lock event pulse |
| ovld_evt | input | 1 | Overload frame event pulse |
| ovrn_evt | input | 1 | Receive overrun event pulse |
| tx_err_evt | input | 1 | Transmit error, counter +8 |
| tx_ok_evt | input | 1 | Successful transmit, counter -1 |
| rx_err_evt | input | 1 | Receive error, counter +1 |
| rx_ok_evt | input | 1 | Successful receive, counter -1 |
| recover_evt | input | 1 | Bus-off recovery complete pulse |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| err_irq | output | 1 | Error interrupt request |
| bus_off | output | 1 | Node is in bus-off |

## Verification
A counter that has drifted shows up at address 5 or 6 on the first read after the edge that sampled the event. The same drift also shows up as a warning, passive or bus-off flag that appears one pulse too early or too late when the counter crosses a threshold. A flag bit that is stuck, or that the clear logic handles wrongly, shows at address 0 or 2 on the first read after the write or event. Through the summary bit and the enables, the same fault reaches `err_irq` in that same cycle. A bus-off state that is held wrongly shows as counters that keep moving after entry, or as `bus_off` staying high after a recovery pulse.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  typedef enum logic [2:0] {
    A_FLAG = 3'd0,
    A_EN   = 3'd1,
    A_SRC  = 3'd2,
    A_IST  = 3'd3,
    A_IEN  = 3'd4,
    A_TEC  = 3'd5,
    A_REC  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  localparam int FLAG_W  = 8;
  localparam int SRC_W   = 7;
  localparam int FB_BERR = 0;
  localparam int FB_WARN = 1;
  localparam int FB_PASS = 2;
  localparam int FB_BOFF = 3;
  localparam int FB_BREC = 4;
  localparam int FB_OVRN = 5;
  localparam int FB_OVLD = 6;
  localparam int FB_LOCK = 7;
  localparam int SUM_BIT = 5;
endpackage

// File: rtl/w0c_flags.sv
module w0c_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr;
    assign clr = wr_en && !wdata[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (evt[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end

    // R5
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> q[i]);
    // R4
    w0c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !q[i]);
    // R4
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !clr) |=> $stable(q[i]));
  end
endmodule

// File: rtl/err_counters.sv
module err_counters #(
  parameter int CNT_W    = 8,
  parameter int TX_INC   = 8,
  parameter int RX_INC   = 1,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             recover,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             busoff,
  output logic             warn_rise,
  output logic             pass_rise,
  output logic             boff_rise,
  output logic             brec_rise
);
  localparam int XW   = CNT_W + 2;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic [XW-1:0]    tx_sum, tx_nx, rx_sum, rx_dec;
  logic [CNT_W-1:0] rx_nx, tec_d, rec_d;
  logic             busoff_d;

  function automatic logic at_or_above(input logic [CNT_W-1:0] t,
                                       input logic [CNT_W-1:0] r,
                                       input int lim);
    return (int'(t) >= lim) || (int'(r) >= lim);
  endfunction

  always_comb begin
    tx_sum = {2'b00, tec} + (tx_err ? XW'(TX_INC) : '0);
    tx_nx  = (tx_ok && tx_sum != '0) ? tx_sum - 1'b1 : tx_sum;
    rx_sum = {2'b00, rec} + (rx_err ? XW'(RX_INC) : '0);
    rx_dec = (rx_ok && rx_sum != '0) ? rx_sum - 1'b1 : rx_sum;
    rx_nx  = (rx_dec > XW'(MAXV)) ? CNT_W'(MAXV) : rx_dec[CNT_W-1:0];

    boff_rise = !busoff && (tx_nx > XW'(MAXV));
    brec_rise = busoff && recover;

    if (busoff) begin
      tec_d    = recover ? '0 : tec;
      rec_d    = recover ? '0 : rec;
      busoff_d = !recover;
    end else begin
      tec_d    = boff_rise ? CNT_W'(MAXV) : tx_nx[CNT_W-1:0];
      rec_d    = rx_nx;
      busoff_d = boff_rise;
    end

    warn_rise = !at_or_above(tec, rec, WARN_LIM) && at_or_above(tec_d, rec_d, WARN_LIM);
    pass_rise = !at_or_above(tec, rec, PASS_LIM) && at_or_above(tec_d, rec_d, PASS_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec    <= '0;
      rec    <= '0;
      busoff <= 1'b0;
    end else begin
      tec    <= tec_d;
      rec    <= rec_d;
      busoff <= busoff_d;
    end
  end

  // R10
  busoff_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busoff |-> (tec == CNT_W'(MAXV)));
  // R10
  busoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff && !recover) |=> (tec == $past(tec) && rec == $past(rec) && busoff));
  // R11
  recover_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff && recover) |=> (tec == '0 && rec == '0 && !busoff));
  // R7
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff && !tx_err && !tx_ok) |=> $stable(tec));
  // R7
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff && !rx_err && !rx_ok) |=> $stable(rec));
endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
  import can_err_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] src_evt,
  input  logic       lock_evt,
  input  logic       ovld_evt,
  input  logic       ovrn_evt,
  input  logic       tx_err_evt,
  input  logic       tx_ok_evt,
  input  logic       rx_err_evt,
  input  logic       rx_ok_evt,
  input  logic       recover_evt,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       err_irq,
  output logic       bus_off
);
  logic [CNT_W-1:0]  tec, rec;
  logic              warn_rise, pass_rise, boff_rise, brec_rise;
  logic [FLAG_W-1:0] flag_evt, flags, en_q;
  logic [SRC_W-1:0]  src_q;
  logic              src_mode_q, ien_q, sum_bit;
  logic              wr_flag, wr_src;

  err_counters #(
    .CNT_W(CNT_W), .TX_INC(8), .RX_INC(1),
    .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tx_err(tx_err_evt), .tx_ok(tx_ok_evt),
    .rx_err(rx_err_evt), .rx_ok(rx_ok_evt),
    .recover(recover_evt),
    .tec(tec), .rec(rec), .busoff(bus_off),
    .warn_rise(warn_rise), .pass_rise(pass_rise),
    .boff_rise(boff_rise), .brec_rise(brec_rise)
  );

  always_comb begin
    flag_evt          = '0;
    flag_evt[FB_BERR] = |src_evt;
    flag_evt[FB_WARN] = warn_rise;
    flag_evt[FB_PASS] = pass_rise;
    flag_evt[FB_BOFF] = boff_rise;
    flag_evt[FB_BREC] = brec_rise;
    flag_evt[FB_OVRN] = ovrn_evt;
    flag_evt[FB_OVLD] = ovld_evt;
    flag_evt[FB_LOCK] = lock_evt;
  end

  assign wr_flag = reg_we && (reg_addr == A_FLAG);
  assign wr_src  = reg_we && (reg_addr == A_SRC);

  w0c_flags #(.W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(flag_evt),
    .wr_en(wr_flag), .wdata(reg_wdata), .q(flags)
  );

  w0c_flags #(.W(SRC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .evt(src_evt),
    .wr_en(wr_src), .wdata(reg_wdata[SRC_W-1:0]), .q(src_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      ien_q      <= 1'b0;
      src_mode_q <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_EN)  en_q       <= reg_wdata;
      if (reg_addr == A_IEN) ien_q      <= reg_wdata[SUM_BIT];
      if (reg_addr == A_SRC) src_mode_q <= reg_wdata[7];
    end
  end

  assign sum_bit = |(flags & en_q);
  assign err_irq = sum_bit && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FLAG:  reg_rdata = flags;
      A_EN:    reg_rdata = en_q;
      A_SRC:   reg_rdata = {src_mode_q, src_q};
      A_IST:   reg_rdata[SUM_BIT] = sum_bit;
      A_IEN:   reg_rdata[SUM_BIT] = ien_q;
      A_TEC:   reg_rdata = 8'(tec);
      A_REC:   reg_rdata = 8'(rec);
      default: reg_rdata = '0;
    endcase
  end

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (flags != '0) && (en_q != '0));
  // R10
  boff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> flags[FB_BOFF]);
  // R2
  berr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> flags[FB_BERR]);
endmodule

// File: tb/can_err_irq_unit_bench.sv
module can_err_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src_evt = '0;
  logic       lock_evt = 0, ovld_evt = 0, ovrn_evt = 0;
  logic       tx_err_evt = 0, tx_ok_evt = 0, rx_err_evt = 0, rx_ok_evt = 0;
  logic       recover_evt = 0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       err_irq, bus_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  can_err_irq_unit u_can_err_irq_unit (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .lock_evt(lock_evt), .ovld_evt(ovld_evt), .ovrn_evt(ovrn_evt),
    .tx_err_evt(tx_err_evt), .tx_ok_evt(tx_ok_evt),
    .rx_err_evt(rx_err_evt), .rx_ok_evt(rx_ok_evt),
    .recover_evt(recover_evt), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_irq(err_irq), .bus_off(bus_off)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    reg_addr = a;
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_tx_err(input int n);
    for (int i = 0; i < n; i++) begin
      tx_err_evt = 1; @(negedge clk); tx_err_evt = 0;
    end
  endtask

  task automatic pulse_rx_err(input int n);
    for (int i = 0; i < n; i++) begin
      rx_err_evt = 1; @(negedge clk); rx_err_evt = 0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 reg after reset", 3'(a), 0);
    chk("R1 err_irq after reset", int'(err_irq), 0);
    chk("R1 bus_off after reset", int'(bus_off), 0);
  endtask

  task automatic t_source();
    do_reset();
    src_evt = 7'h48; @(negedge clk); src_evt = '0;
    rd_chk("R2 source latch", 3'd2, 'h48);
    rd_chk("R2 bus error flag", 3'd0, 'h01);
    wr(3'd2, 8'hFF);
    rd_chk("R2 mode bit write, R4 write one keeps", 3'd2, 'hC8);
    wr(3'd2, 8'h88);
    rd_chk("R4 source write zero clears bit 6", 3'd2, 'h88);
    rd_chk("R4 source write leaves flag reg", 3'd0, 'h01);
  endtask

  task automatic t_misc_events();
    do_reset();
    lock_evt = 1; ovld_evt = 1; ovrn_evt = 1; @(negedge clk);
    lock_evt = 0; ovld_evt = 0; ovrn_evt = 0;
    rd_chk("R3 lock overload overrun flags", 3'd0, 'hE0);
    wr(3'd0, 8'hBF);
    rd_chk("R4 clear only bit 6", 3'd0, 'hA0);
    wr(3'd0, 8'hFF);
    rd_chk("R4 write ones no effect", 3'd0, 'hA0);
  endtask

  task automatic t_collide();
    do_reset();
    src_evt = 7'h01; @(negedge clk); src_evt = '0;
    reg_we = 1; reg_addr = 3'd0; reg_wdata = 8'h00;
    src_evt = 7'h02; ovrn_evt = 1;
    @(negedge clk);
    reg_we = 0; src_evt = '0; ovrn_evt = 0;
    rd_chk("R5 event wins over clear", 3'd0, 'h21);
  endtask

  task automatic t_irq();
    do_reset();
    ovrn_evt = 1; @(negedge clk); ovrn_evt = 0;
    rd_chk("R6 status masked by enable", 3'd3, 'h00);
    wr(3'd1, 8'h20);
    rd_chk("R6 status summary", 3'd3, 'h20);
    chk("R6 irq gated by int enable", int'(err_irq), 0);
    wr(3'd4, 8'hFF);
    rd_chk("R6 int enable reads bit 5", 3'd4, 'h20);
    chk("R6 irq asserted", int'(err_irq), 1);
    wr(3'd3, 8'h00);
    rd_chk("R12 status write ignored", 3'd3, 'h20);
    wr(3'd1, 8'h10);
    chk("R6 irq off on other enable", int'(err_irq), 0);
    wr(3'd1, 8'h20);
    wr(3'd0, 8'h00);
    chk("R6 irq off after clear", int'(err_irq), 0);
    rd_chk("R12 unmapped reads 0", 3'd7, 0);
  endtask

  task automatic t_counters();
    do_reset();
    pulse_tx_err(3);
    rd_chk("R7 tx +8 each", 3'd5, 24);
    tx_ok_evt = 1; @(negedge clk); @(negedge clk); tx_ok_evt = 0;
    rd_chk("R7 tx -1 each", 3'd5, 22);
    pulse_rx_err(2);
    rd_chk("R7 rx +1 each", 3'd6, 2);
    rx_ok_evt = 1; repeat (3) @(negedge clk); rx_ok_evt = 0;
    rd_chk("R7 rx floor at 0", 3'd6, 0);
    tx_err_evt = 1; tx_ok_evt = 1; @(negedge clk);
    tx_err_evt = 0; tx_ok_evt = 0;
    rd_chk("R7 tx err and ok same cycle", 3'd5, 29);
    wr(3'd5, 8'h00);
    rd_chk("R12 counter write ignored", 3'd5, 29);
  endtask

  task automatic t_warn();
    do_reset();
    pulse_tx_err(11);
    rd_chk("R8 no warning at 88", 3'd0, 'h00);
    pulse_tx_err(1);
    rd_chk("R8 warning at 96", 3'd0, 'h02);
    wr(3'd0, 8'h00);
    pulse_tx_err(1);
    rd_chk("R8 no re-raise above threshold", 3'd0, 'h00);
    do_reset();
    pulse_rx_err(95);
    rd_chk("R8 rx 95 no warning", 3'd0, 'h00);
    pulse_rx_err(1);
    rd_chk("R8 rx warning at 96", 3'd0, 'h02);
  endtask

  task automatic t_passive_busoff();
    do_reset();
    pulse_tx_err(15);
    rd_chk("R9 no passive at 120", 3'd0, 'h02);
    pulse_tx_err(1);
    rd_chk("R9 passive at 128", 3'd0, 'h06);
    pulse_tx_err(15);
    rd_chk("R10 tx 248 not bus-off", 3'd5, 248);
    chk("R10 bus_off low at 248", int'(bus_off), 0);
    pulse_tx_err(1);
    chk("R10 bus_off entry", int'(bus_off), 1);
    rd_chk("R10 bus-off flag", 3'd0, 'h0E);
    rd_chk("R10 tec reads 255", 3'd5, 255);
    rx_err_evt = 1; tx_ok_evt = 1; @(negedge clk);
    rx_err_evt = 0; tx_ok_evt = 0;
    rd_chk("R10 tx ignored in bus-off", 3'd5, 255);
    rd_chk("R10 rx ignored in bus-off", 3'd6, 0);
    wr(3'd0, 8'h00);
    recover_evt = 1; @(negedge clk); recover_evt = 0;
    chk("R11 bus_off cleared", int'(bus_off), 0);
    rd_chk("R11 recovery flag", 3'd0, 'h10);
    rd_chk("R11 tec cleared", 3'd5, 0);
    wr(3'd0, 8'h00);
    recover_evt = 1; @(negedge clk); recover_evt = 0;
    rd_chk("R11 recover ignored outside bus-off", 3'd0, 'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_source();
    t_misc_events();
    t_collide();
    t_irq();
    t_counters();
    t_warn();
    t_passive_busoff();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule